// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Front End

This block is the control and datapath front end of a synchronous SRAM whose 32-bit word is split into four byte lanes. Every address, control and write-data input is sampled into a register on the rising clock edge. Those registered values then drive a behavioural storage array and a registered read path, which gives a two-stage pipeline. Writes land on the edge after capture. Read data reaches the output register on that same edge.

Three chip-select inputs must all be active for a cycle to take effect. Their polarities are fixed: the first is active-low, the second active-high and the third active-low. A cycle that is selected writes when either the global write input or the byte-write enable is high, and reads otherwise. Global write stores the whole word. The byte-write enable stores only the lanes picked by the per-lane selects.

The block drives no pins itself. It produces the data word and a drive enable for an external three-state pad. The enable follows an asynchronous output-enable input. It is held low for the output cycle of a read that directly follows a deselected cycle or reset. The burst address sequence is produced outside the block and arrives on the address input. The interface has no valid/ready handshake because the array accepts one operation every clock with no back-pressure.

Top module: `sram_pipe_ctrl`

## Requirements
- R1: A cycle is selected only when `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0 at the sampling edge. A cycle that is not selected writes nothing, leaves `dq_o` unchanged and gives `dq_oe_o`=0 in its output cycle.
- R2: A selected read captured at edge k shows the stored word of its address on `dq_o` after edge k+1. A write captured at edge k is visible to any read captured at edge k+1 or later.
- R3: When `all_wr_i`=1 in a selected cycle, all four lanes are written, whatever the values of `byte_wr_en_i` and `lane_wr_i`.
- R4: When `all_wr_i`=0 and `byte_wr_en_i`=1, the only lanes written are those whose bit in `lane_wr_i` is 1. Lane i is bits [8i+7:8i] of the word. The other lanes keep their old contents.
- R5: When `all_wr_i`=0 and `byte_wr_en_i`=0, a selected cycle is a read. In that case `lane_wr_i` and `wdata_i` have no effect on the stored data.
- R6: `dq_o` changes only in the output cycle of a selected read. It holds its value through write and deselected cycles.
- R7: `dq_oe_o` is 1 only while `out_en_i`=1 and the output register holds data from an unmasked read. It follows `out_en_i` combinationally, with no clock edge needed.
- R8: A read whose previous captured cycle was deselected, or which is the first cycle after reset, keeps `dq_oe_o`=0 for its whole output cycle. A read that directly follows a selected cycle is not masked.
- R9: In the output cycle of a write, `dq_oe_o`=0.
- R10: During and right after reset, `dq_o`=0 and `dq_oe_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, with the burst step already applied |
| sel_a_n_i | input | 1 | Chip select A, active-low |
| sel_b_i | input | 1 | Chip select B, active-high |
| sel_c_n_i | input | 1 | Chip select C, active-low |
| all_wr_i | input | 1 | Global write: stores all four lanes |
| byte_wr_en_i | input | 1 | Qualifies the per-lane write selects |
| lane_wr_i | input | LANES | Per-lane write selects |
| wdata_i | input | LANES*LANE_W | Write data |
| out_en_i | input | 1 | Asynchronous output enable |
| dq_o | output | LANES*LANE_W | Registered read data |
| dq_oe_o | output | 1 | Drive enable for the external three-state data pad |

## Verification
The assertions check the following on every cycle:
- a deselected cycle or a global write is decoded into the correct registered cycle kind;
- the output word holds steady across non-read cycles;
- the drive enable is low in the output cycle of a write and in the output cycle of a read that follows a deselected cycle.

Only the bench scenarios can show that stored contents are correct. This covers lane merging under partial byte writes, read-after-write ordering through the pipeline, and the immunity of the array to lane selects and write data during reads. It also covers the combinational response of the drive enable to a change of the output enable in the middle of a cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_t;
endpackage

// File: rtl/sram_in_reg.sv
module sram_in_reg
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      sel_a_n_i,
  input  logic                      sel_b_i,
  input  logic                      sel_c_n_i,
  input  logic                      all_wr_i,
  input  logic                      byte_wr_en_i,
  input  logic [LANES-1:0]          lane_wr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output cyc_kind_t                 kind_q,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [LANES-1:0]          mask_q,
  output logic [LANES*LANE_W-1:0]   wdata_q
);
  localparam int WORD_W = LANES * LANE_W;

  logic             hit;
  logic [LANES-1:0] wmask;
  cyc_kind_t        kind_d;

  // chip-select decode: fixed polarities low / high / low
  assign hit = ~sel_a_n_i & sel_b_i & ~sel_c_n_i;

  always_comb begin
    if (all_wr_i)          wmask = {LANES{1'b1}};
    else if (byte_wr_en_i) wmask = lane_wr_i;
    else                   wmask = '0;
  end

  always_comb begin
    if (!hit)                         kind_d = CYC_IDLE;
    else if (all_wr_i | byte_wr_en_i) kind_d = CYC_WRITE;
    else                              kind_d = CYC_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CYC_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      wdata_q <= {WORD_W{1'b0}};
    end else begin
      kind_q  <= kind_d;
      addr_q  <= addr_i;
      mask_q  <= wmask;
      wdata_q <= wdata_i;
    end
  end

  AST_DESEL_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n_i || !sel_b_i || sel_c_n_i) |=> (kind_q == CYC_IDLE)); // R1

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n_i && sel_b_i && !sel_c_n_i && all_wr_i)
      |=> (kind_q == CYC_WRITE && (&mask_q))); // R3

  AST_PLAIN_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a_n_i && sel_b_i && !sel_c_n_i && !all_wr_i && !byte_wr_en_i)
      |=> (kind_q == CYC_READ)); // R5
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES-1:0]          mask_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  output logic [LANES*LANE_W-1:0]   rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_i && mask_i[l])
        store[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = store[addr_i];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_ctrl_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_kind_t         kind_i,
  input  logic [WORD_W-1:0] rdata_i,
  input  logic              out_en_i,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic [WORD_W-1:0] dout_q;
  logic              rd_vld_q;
  logic              mask_q;
  logic              prev_idle_q;
  logic              is_read;

  assign is_read = (kind_i == CYC_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q      <= '0;
      rd_vld_q    <= 1'b0;
      mask_q      <= 1'b1;
      prev_idle_q <= 1'b1;
    end else begin
      if (is_read) dout_q <= rdata_i;
      rd_vld_q    <= is_read;
      mask_q      <= prev_idle_q;
      prev_idle_q <= (kind_i == CYC_IDLE);
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = out_en_i & rd_vld_q & ~mask_q;

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i != CYC_READ) |=> $stable(dq_o)); // R6

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_WRITE) |=> !dq_oe_o); // R9

  AST_FIRST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == CYC_READ && $past(kind_i) == CYC_IDLE) |=> !dq_oe_o); // R8
endmodule

// File: rtl/sram_pipe_ctrl.sv
module sram_pipe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      sel_a_n_i,
  input  logic                      sel_b_i,
  input  logic                      sel_c_n_i,
  input  logic                      all_wr_i,
  input  logic                      byte_wr_en_i,
  input  logic [LANES-1:0]          lane_wr_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  logic                      out_en_i,
  output logic [LANES*LANE_W-1:0]   dq_o,
  output logic                      dq_oe_o
);
  localparam int WORD_W = LANES * LANE_W;

  cyc_kind_t         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata;

  sram_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (addr_i),
    .sel_a_n_i    (sel_a_n_i),
    .sel_b_i      (sel_b_i),
    .sel_c_n_i    (sel_c_n_i),
    .all_wr_i     (all_wr_i),
    .byte_wr_en_i (byte_wr_en_i),
    .lane_wr_i    (lane_wr_i),
    .wdata_i      (wdata_i),
    .kind_q       (kind_q),
    .addr_q       (addr_q),
    .mask_q       (mask_q),
    .wdata_q      (wdata_q)
  );

  sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_i    (kind_q == CYC_WRITE),
    .addr_i  (addr_q),
    .mask_i  (mask_q),
    .wdata_i (wdata_q),
    .rdata_o (rdata)
  );

  sram_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind_i   (kind_q),
    .rdata_i  (rdata),
    .out_en_i (out_en_i),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!dq_oe_o && dq_o == '0)); // R10
endmodule

// File: tb/sram_pipe_ctrl_bench.sv
module sram_pipe_ctrl_bench;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              sel_a_n_i = 1'b1, sel_b_i = 1'b0, sel_c_n_i = 1'b1;
  logic              all_wr_i = 1'b0, byte_wr_en_i = 1'b0;
  logic [3:0]        lane_wr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic              out_en_i = 1'b1;
  logic [31:0]       dq_o;
  logic              dq_oe_o;

  always #5 clk = ~clk;

  sram_pipe_ctrl #(.ADDR_W(ADDR_W), .LANES(4), .LANE_W(8)) u_sram_pipe_ctrl (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .sel_a_n_i(sel_a_n_i), .sel_b_i(sel_b_i), .sel_c_n_i(sel_c_n_i),
    .all_wr_i(all_wr_i), .byte_wr_en_i(byte_wr_en_i), .lane_wr_i(lane_wr_i),
    .wdata_i(wdata_i), .out_en_i(out_en_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] ref_mem [DEPTH];

  // kind: 0 idle, 1 read, 2 write
  int          p1_kind = 0, p2_kind = 0;
  logic [31:0] p1_data = '0, p2_data = '0;
  logic        p1_mask = 1'b1, p2_mask = 1'b1;
  string       p1_tag = "R2", p2_tag = "R2";
  logic        last_idle = 1'b1;
  logic [31:0] exp_dout = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old_w,
                                        input logic [31:0] new_w,
                                        input logic [3:0] m);
    logic [31:0] r = old_w;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*8 +: 8] = new_w[l*8 +: 8];
    return r;
  endfunction

  task automatic step(input logic an, input logic b, input logic cn,
                      input logic gw, input logic bwe, input logic [3:0] ls,
                      input logic [ADDR_W-1:0] ad, input logic [31:0] wd,
                      input logic oe, input string tag);
    logic exp_oe;
    bit   hit;
    string oe_tag;
    // check result of the op driven two steps back
    if (p2_kind == 1) exp_dout = p2_data;
    chk(dq_o === exp_dout, (p2_kind == 1) ? p2_tag : "R6", dq_o, exp_dout);
    exp_oe = out_en_i & (p2_kind == 1) & ~p2_mask;
    oe_tag = (p2_kind == 0) ? "R1" : (p2_kind == 2) ? "R9" : p2_mask ? "R8" : "R7";
    chk(dq_oe_o === exp_oe, oe_tag, {31'd0, dq_oe_o}, {31'd0, exp_oe});
    if (p2_kind == 1 && !p2_mask) begin
      out_en_i = ~out_en_i;
      #1;
      chk(dq_oe_o === out_en_i, "R7", {31'd0, dq_oe_o}, {31'd0, out_en_i});
      out_en_i = ~out_en_i;
      #1;
    end
    p2_kind = p1_kind; p2_data = p1_data; p2_mask = p1_mask; p2_tag = p1_tag;
    hit = !an && b && !cn;
    if (!hit) p1_kind = 0;
    else if (gw || bwe) p1_kind = 2;
    else p1_kind = 1;
    if (p1_kind == 2) ref_mem[ad] = merge(ref_mem[ad], wd, gw ? 4'hF : ls);
    if (p1_kind == 1) p1_data = ref_mem[ad];
    p1_mask = last_idle;
    p1_tag  = tag;
    last_idle = !hit;
    sel_a_n_i = an; sel_b_i = b; sel_c_n_i = cn;
    all_wr_i = gw; byte_wr_en_i = bwe; lane_wr_i = ls;
    addr_i = ad; wdata_i = wd; out_en_i = oe;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, '0, 32'h0, 1'b1, "R2");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(dq_o === 32'd0, "R10", dq_o, 32'd0);
    chk(dq_oe_o === 1'b0, "R10", {31'd0, dq_oe_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_oe_o === 1'b0, "R10", {31'd0, dq_oe_o}, 32'd0);
    for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
    // preload every word with a global write; lane selects are noise (R3)
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'($urandom), 4'($urandom), ADDR_W'(a),
           $urandom, 1'b1, "R3");
    // R3: global write without byte enable, no lane selects
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd5, 32'hA5A5_1234, 1'b1, "R3");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd5, 32'h0, 1'b1, "R3");
    // R4: partial byte write, lanes 0 and 2
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0101, 6'd6, 32'hDEAD_BEEF, 1'b1, "R4");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd6, 32'h0, 1'b1, "R4");
    // R5: read carrying lane selects and data must not write
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 6'd6, 32'h1111_2222, 1'b1, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd6, 32'h0, 1'b1, "R5");
    // R1: writes with each select inactive must not land
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'h0, 6'd7, 32'h0BAD_0001, 1'b1, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 6'd7, 32'h0BAD_0002, 1'b1, "R1");
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 6'd7, 32'h0BAD_0003, 1'b1, "R1");
    // R8: first read after deselect is masked, the next one drives
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd7, 32'h0, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd8, 32'h0, 1'b1, "R8");
    // R9: write then idle
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1000, 6'd8, 32'hCAFE_0000, 1'b1, "R9");
    idle();
    idle();
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic on;
      logic [1:0] which;
      logic an, b, cn;
      on = ($urandom % 5) != 0;
      which = 2'($urandom % 3);
      an = on ? 1'b0 : (which == 0);
      b  = on ? 1'b1 : (which != 1);
      cn = on ? 1'b0 : (which == 2);
      step(an, b, cn, ($urandom % 6) == 0, ($urandom % 3) == 0, 4'($urandom),
           ADDR_W'($urandom % 16), $urandom, ($urandom % 4) != 0, "R2");
    end
    idle();
    idle();
    idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule